// File: doc/BRIEF.md
# Transceiver Driver-Enable Sequencer

This block controls the driver-enable line of a half-duplex line transceiver that sits behind a UART transmitter. When the data holding side asks for a frame, the block turns the driver on. It then waits a programmable lead time and issues a one-cycle grant that lets the serialiser emit its start bit. After the serialiser reports the end of the last stop bit, the block keeps the driver on for a programmable tail time and then releases the line.

All delays are counted in sample units. The `tick` input pulses once per 1/16 of a bit. In 16x mode one sample unit is one tick. In 8x mode a sample unit is 1/8 of a bit, which is two ticks. The two 5-bit timing fields and the oversampling mode are captured only while the block is disabled. Dropping the enable stops everything at once. A frame that is requested while the tail is running is held back: the tail must finish, and then a full lead time must pass, before that frame is granted.

Top module: `txen_sequencer`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `drv_en` shows the inactive level (equal to `de_pol`) and `frame_grant` is low.
- R2: `drv_en` goes active in the cycle after an accepted `frame_req`. With a lead field L in 16x mode, `frame_grant` is issued with the (L+1)-th tick after that, and `drv_en` stays active throughout.
- R3: A lead field of zero issues `frame_grant` with the first tick after the request.
- R4: In 8x mode (`over8`=1) each sample unit is two ticks. A lead field L grants on tick 2L+1, and a tail field T releases the driver on tick 2T+1.
- R5: After `stop_done`, `drv_en` stays active until the (T+1)-th tick in 16x mode, where T is the tail field, and then goes inactive.
- R6: A `frame_req` that arrives while the tail runs keeps `drv_en` active. The grant then comes only after the full tail count followed by a full lead count (T+1 ticks, then L+1 ticks, in 16x mode).
- R7: `frame_grant` is a single-cycle pulse.
- R8: When `enable` is low, `drv_en` is inactive from the next cycle, no grant is issued, and any pending request is discarded.
- R9: Changes to `lead_time`, `tail_time` and `over8` while `enable` is high have no effect. The values in force are those present during the last cycle in which `enable` was low.
- R10: `de_pol`=1 makes the active level of `drv_en` low and the inactive level high. It does not change any timing.
- R11: Without `tick` pulses, no count advances and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global enable. Low returns the block to idle and opens the configuration capture |
| tick | input | 1 | Base sample tick, one pulse per 1/16 bit |
| frame_req | input | 1 | Frame request strobe from the data holding side |
| stop_done | input | 1 | End of the last stop bit, from the serialiser |
| over8 | input | 1 | Oversampling mode: 1 = 8x, 0 = 16x |
| lead_time | input | FW | Delay from driver on to start bit, in sample units |
| tail_time | input | FW | Delay from end of stop bit to driver off, in sample units |
| de_pol | input | 1 | Driver-enable polarity: 1 = active low |
| drv_en | output | 1 | Driver-enable pin, registered |
| frame_grant | output | 1 | One-cycle grant that releases the serialiser's start bit |

## Verification
The hardest case to reach is a request that arrives inside the tail window. It needs a complete frame to have been granted, a stop indication to be delivered, and then a new request to be placed while the tail count is still running. Each bench task that checks this drives the ticks one cycle at a time. It injects `stop_done` and then the new request in cycles that carry no tick, so the tail is known not to have started counting. The bench then counts ticks until the grant appears and checks that the driver never dropped during the wait.

// File: rtl/de_seq_pkg.sv
package de_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LEAD   = 2'd1,
    SEQ_ACTIVE = 2'd2,
    SEQ_TAIL   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/txen_cfg_hold.sv
// Captures timing fields and oversampling mode only while the block is disabled.
module txen_cfg_hold #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          over8_in,
  input  logic [FW-1:0] lead_in,
  input  logic [FW-1:0] tail_in,
  output logic          over8_q,
  output logic [FW-1:0] lead_q,
  output logic [FW-1:0] tail_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      over8_q <= 1'b0;
      lead_q  <= '0;
      tail_q  <= '0;
    end else if (!enable) begin
      over8_q <= over8_in;
      lead_q  <= lead_in;
      tail_q  <= tail_in;
    end
  end
endmodule

// File: rtl/txen_unit_timer.sv
// Counts base ticks; expires on the tick where the count equals the target.
module txen_unit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = tick && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txen_sequencer.sv
module txen_sequencer #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          tick,
  input  logic          frame_req,
  input  logic          stop_done,
  input  logic          over8,
  input  logic [FW-1:0] lead_time,
  input  logic [FW-1:0] tail_time,
  input  logic          de_pol,
  output logic          drv_en,
  output logic          frame_grant
);
  import de_seq_pkg::*;

  localparam int CW = FW + 1;

  logic          over8_q;
  logic [FW-1:0] lead_q;
  logic [FW-1:0] tail_q;
  logic [FW-1:0] field_sel;
  logic [CW-1:0] target;
  logic          t_done;
  logic          t_clear;

  seq_state_t st, nxt;
  logic       pend, pend_n;
  logic       grant_n;

  txen_cfg_hold #(.FW(FW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .over8_in (over8),
    .lead_in  (lead_time),
    .tail_in  (tail_time),
    .over8_q  (over8_q),
    .lead_q   (lead_q),
    .tail_q   (tail_q)
  );

  // A sample unit is two base ticks in 8x mode.
  assign field_sel = (st == SEQ_LEAD) ? lead_q : tail_q;
  assign target    = over8_q ? {field_sel, 1'b0} : {1'b0, field_sel};

  txen_unit_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (t_clear),
    .tick   (tick),
    .target (target),
    .done   (t_done)
  );

  always_comb begin
    nxt     = st;
    pend_n  = pend;
    grant_n = 1'b0;
    case (st)
      SEQ_IDLE: begin
        if (frame_req) nxt = SEQ_LEAD;
      end
      SEQ_LEAD: begin
        if (t_done) begin
          nxt     = SEQ_ACTIVE;
          grant_n = 1'b1;
        end
      end
      SEQ_ACTIVE: begin
        if (frame_req) pend_n = 1'b1;
        if (stop_done) nxt = SEQ_TAIL;
      end
      SEQ_TAIL: begin
        if (frame_req) pend_n = 1'b1;
        if (t_done) begin
          nxt    = pend_n ? SEQ_LEAD : SEQ_IDLE;
          pend_n = 1'b0;
        end
      end
      default: nxt = SEQ_IDLE;
    endcase
    if (!enable) begin
      nxt     = SEQ_IDLE;
      pend_n  = 1'b0;
      grant_n = 1'b0;
    end
  end

  // Restart the unit count on every state change and while not counting.
  assign t_clear = (nxt != st) || (st == SEQ_IDLE) || (st == SEQ_ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SEQ_IDLE;
      pend        <= 1'b0;
      frame_grant <= 1'b0;
      drv_en      <= de_pol;
    end else begin
      st          <= nxt;
      pend        <= pend_n;
      frame_grant <= grant_n;
      drv_en      <= (nxt != SEQ_IDLE) ^ de_pol;
    end
  end
endmodule

// File: rtl/txen_sequencer_chk.sv
module txen_sequencer_chk #(
  parameter int FW = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   enable,
  input logic                   tick,
  input logic                   de_pol,
  input logic                   drv_en,
  input logic                   frame_grant,
  input de_seq_pkg::seq_state_t st,
  input logic [FW-1:0]          lead_q,
  input logic [FW-1:0]          tail_q,
  input logic                   over8_q
);
  import de_seq_pkg::*;

  a_r7_grant_one_cycle: assert property (@(posedge clk) disable iff (rst)
    frame_grant |=> !frame_grant);

  a_r7_grant_enters_active: assert property (@(posedge clk) disable iff (rst)
    frame_grant |-> (st == SEQ_ACTIVE));

  a_r8_disable_idles: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (st == SEQ_IDLE) && !frame_grant);

  a_r11_no_tick_no_grant: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !frame_grant);

  a_r1_idle_inactive: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_IDLE) |-> (drv_en == $past(de_pol)));

  a_r10_busy_active: assert property (@(posedge clk) disable iff (rst)
    (st != SEQ_IDLE) |-> (drv_en != $past(de_pol)));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(lead_q) && $stable(tail_q) && $stable(over8_q));
endmodule

bind txen_sequencer txen_sequencer_chk #(.FW(FW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .tick        (tick),
  .de_pol      (de_pol),
  .drv_en      (drv_en),
  .frame_grant (frame_grant),
  .st          (st),
  .lead_q      (lead_q),
  .tail_q      (tail_q),
  .over8_q     (over8_q)
);

// File: tb/txen_sequencer_test.sv
module txen_sequencer_test;
  localparam int FW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          tick = 1'b0;
  logic          frame_req = 1'b0;
  logic          stop_done = 1'b0;
  logic          over8 = 1'b0;
  logic [FW-1:0] lead_time = '0;
  logic [FW-1:0] tail_time = '0;
  logic          de_pol = 1'b0;
  logic          drv_en;
  logic          frame_grant;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txen_sequencer #(.FW(FW)) uut (
    .clk (clk), .rst (rst), .enable (enable), .tick (tick),
    .frame_req (frame_req), .stop_done (stop_done), .over8 (over8),
    .lead_time (lead_time), .tail_time (tail_time), .de_pol (de_pol),
    .drv_en (drv_en), .frame_grant (frame_grant)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, sample just after the rising edge.
  task automatic step(input logic t, input logic r, input logic s);
    @(negedge clk);
    tick = t; frame_req = r; stop_done = s;
    @(posedge clk);
    #1;
  endtask

  task automatic configure(input int lead, input int tail, input logic o8, input logic pol);
    @(negedge clk);
    enable = 1'b0; lead_time = FW'(lead); tail_time = FW'(tail);
    over8 = o8; de_pol = pol;
    step(0, 0, 0);
    step(0, 0, 0);
    enable = 1'b1;
  endtask

  // Tick every cycle until grant; reports ticks used and whether the driver held active.
  task automatic ticks_to_grant(output int n, output bit held);
    n = 0; held = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step(1, 0, 0);
      n++;
      if (drv_en == de_pol) held = 1'b0;
      if (frame_grant) break;
    end
  endtask

  task automatic ticks_to_release(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step(1, 0, 0);
      n++;
      if (drv_en == de_pol) break;
    end
  endtask

  task automatic t_reset;
    check(drv_en == 1'b0, "R1 drv_en after reset", drv_en, 0);
    check(frame_grant == 1'b0, "R1 grant after reset", frame_grant, 0);
  endtask

  task automatic t_lead_16x;
    int n; bit held;
    configure(3, 2, 0, 0);
    step(0, 1, 0);
    check(drv_en == 1'b1, "R2 drv_en on after request", drv_en, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    check(frame_grant == 1'b0, "R11 no grant without ticks", frame_grant, 0);
    check(drv_en == 1'b1, "R11 driver held without ticks", drv_en, 1);
    ticks_to_grant(n, held);
    check(n == 4, "R2 lead 3 in 16x", n, 4);
    check(held, "R2 driver active during lead", held, 1);
    step(0, 0, 0);
    check(frame_grant == 1'b0, "R7 grant single cycle", frame_grant, 0);
    step(0, 0, 1);
    ticks_to_release(n);
    check(n == 3, "R5 tail 2 in 16x", n, 3);
    step(0, 0, 0);
    check(drv_en == 1'b0 && frame_grant == 1'b0, "R1 idle after tail", drv_en, 0);
  endtask

  task automatic t_lead_zero;
    int n; bit held;
    configure(0, 0, 0, 0);
    step(0, 1, 0);
    ticks_to_grant(n, held);
    check(n == 1, "R3 zero lead", n, 1);
    step(0, 0, 1);
    ticks_to_release(n);
    check(n == 1, "R3 zero tail", n, 1);
  endtask

  task automatic t_over8;
    int n; bit held;
    configure(3, 2, 1, 0);
    step(0, 1, 0);
    ticks_to_grant(n, held);
    check(n == 7, "R4 lead 3 in 8x", n, 7);
    step(0, 0, 1);
    ticks_to_release(n);
    check(n == 5, "R4 tail 2 in 8x", n, 5);
  endtask

  task automatic t_tail_request;
    int n; bit held;
    configure(1, 2, 0, 0);
    step(0, 1, 0);
    ticks_to_grant(n, held);
    step(0, 0, 1);
    step(0, 1, 0);
    ticks_to_grant(n, held);
    check(n == 5, "R6 tail then lead before grant", n, 5);
    check(held, "R6 driver held across tail and lead", held, 1);
  endtask

  task automatic t_disable;
    int n; bit held;
    configure(4, 4, 0, 0);
    step(0, 1, 0);
    step(1, 0, 0);
    @(negedge clk); enable = 1'b0;
    step(1, 0, 0);
    check(drv_en == 1'b0, "R8 drv_en off after disable", drv_en, 0);
    @(negedge clk); enable = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0);
      if (frame_grant || drv_en) n++;
    end
    check(n == 0, "R8 aborted frame not resumed", n, 0);
  endtask

  task automatic t_cfg_frozen;
    int n; bit held;
    configure(1, 0, 0, 0);
    @(negedge clk); lead_time = 5'd10; over8 = 1'b1;
    step(0, 1, 0);
    ticks_to_grant(n, held);
    check(n == 2, "R9 changes while enabled ignored", n, 2);
    step(0, 0, 1);
    step(1, 0, 0);
  endtask

  task automatic t_polarity;
    int n; bit held;
    configure(2, 1, 0, 1);
    check(drv_en == 1'b1, "R10 inverted idle level", drv_en, 1);
    step(0, 1, 0);
    check(drv_en == 1'b0, "R10 inverted active level", drv_en, 0);
    ticks_to_grant(n, held);
    check(n == 3, "R10 timing unchanged by polarity", n, 3);
    step(0, 0, 1);
    ticks_to_release(n);
    check(n == 2 && drv_en == 1'b1, "R10 inverted release", n, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_lead_16x();
    t_lead_zero();
    t_over8();
    t_tail_request();
    t_disable();
    t_cfg_frozen();
    t_polarity();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule